// File: doc/BRIEF.md
# Virtual-to-Physical DMA Channel Binder

This block shares a small pool of physical DMA channels among a larger set of virtual request channels. A client owns its virtual channel for as long as it likes, but a physical channel is tied to it only while it has queued work. When a virtual channel gets new work it joins the back of a first-come waiting line. Each cycle, every free physical channel, taken in ascending index order, picks up the oldest waiting virtual channel. The binding ends as soon as the engine reports that the bound channel has run out of work, or when the client cancels its channel.

Clients can also hold a channel. A held channel that is still waiting leaves the line. A held channel that is already bound keeps its binding but has the run and interrupt enables of its physical channel dropped. Releasing the hold puts an unbound channel back at the end of the line if it still has work, or raises the enables again if the channel is bound. The block drives a binding table, a per-client bound flag, per-physical-channel run enables and one-cycle start pulses for the transfer engine.

Top module: `vdma_chan_alloc`

## Requirements
- R1: After reset no physical channel is bound. All `bind_valid_o`, `bound_o`, `start_o` and `run_en_o` bits are 0, and the waiting line is empty.
- R2: An `issue_i` pulse on a virtual channel that is unbound, not waiting and not held puts it in the waiting line at that clock edge. If a physical channel is free, it is bound at the next edge: `bind_valid_o[p]` goes to 1, field `bind_vch_o[p*VW +: VW]` holds the virtual index, `run_en_o[p]` goes to 1, and `bound_o[v]` goes to 1.
- R3: Virtual channels issued in the same cycle join the line in ascending virtual index. Free physical channels are served in ascending physical index, each taking the oldest waiting entry.
- R4: `issue_i` has no effect on a channel that is already bound or already waiting. A virtual channel is never bound to more than one physical channel.
- R5: While no physical channel is free, issued channels wait. When a channel is freed, the oldest waiting channel is bound to it one edge after the release.
- R6: A `done_i` pulse on a bound virtual channel clears both its binding and `bound_o[v]` at that edge. The physical channel becomes free.
- R7: A `term_i` pulse on a bound channel clears its binding and its run enable at that edge. On a waiting channel it removes the channel from the line, and that channel is never bound.
- R8: A `pause_i` pulse on a waiting, unbound channel removes it from the line and marks it held. A held channel that receives `issue_i` is not queued.
- R9: A `resume_i` pulse on a held, unbound channel clears the hold and, only if `work_i[v]` is 1, appends it to the end of the line.
- R10: `pause_i` on a bound channel clears `run_en_o[p]` while the binding stays. A later `resume_i` sets `run_en_o[p]` again.
- R11: Every newly bound physical channel gets a one-cycle `start_o[p]` pulse. Several physical channels may start in the same cycle.
- R12: The waiting line holds up to NUM_VCH entries and never overflows. Any mix of issued channels is served in the order it arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | NUM_VCH | Pulse: new work issued on a virtual channel |
| work_i | input | NUM_VCH | Level: virtual channel still has issued work |
| pause_i | input | NUM_VCH | Pulse: hold request |
| resume_i | input | NUM_VCH | Pulse: release of a hold |
| term_i | input | NUM_VCH | Pulse: cancel the channel |
| done_i | input | NUM_VCH | Pulse: bound channel finished with no further work |
| bind_vch_o | output | NUM_PCH*VW | Virtual index served by each physical channel |
| bind_valid_o | output | NUM_PCH | Physical channel is bound |
| bound_o | output | NUM_VCH | Virtual channel currently holds a physical channel |
| start_o | output | NUM_PCH | One-cycle pulse on a new binding |
| run_en_o | output | NUM_PCH | Run and interrupt enable of each physical channel |

## Verification
The allocator is tested with three kinds of traffic: a single issue to an idle pool, a burst of four issues in one cycle into the remaining free channels, and a late wave of eleven issues arriving while nearly every channel is busy. The burst separates arrival order from physical scan order. The late wave tests the line's depth and whether it stays first-come across releases. Repeat issues on bound or waiting channels show whether duplicates are filtered. Holds, resumes with and without remaining work, and cancels are each applied to both a waiting channel and a bound channel, because the block must treat the two cases differently. Every start pulse is compared against an expected stream of (physical, virtual) pairs, so any start that is extra, missing or in the wrong order is caught.

// File: rtl/vdma_alloc_pkg.sv
package vdma_alloc_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vdma_pend_queue.sv
module vdma_pend_queue #(
  parameter int NV = 16,
  parameter int VW = 4,
  parameter int CW = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NV-1:0]          rm_i,
  input  logic [CW-1:0]          pop_n_i,
  input  logic [NV-1:0]          push_i,
  output logic [NV-1:0][VW-1:0]  ent_o,
  output logic [CW-1:0]          cnt_o,
  output logic [NV-1:0]          member_o
);
  logic [NV-1:0][VW-1:0] ent_q, ent_d, comp;
  logic [CW-1:0]         cnt_q, cnt_d, kept;
  logic [NV-1:0]         member_q, member_d, pop_mask;

  // compact survivors of removal, keeping age order
  always_comb begin
    comp = '0;
    kept = '0;
    for (int i = 0; i < NV; i++) begin
      if (CW'(i) < cnt_q && !rm_i[ent_q[i]]) begin
        comp[kept[VW-1:0]] = ent_q[i];
        kept = kept + 1'b1;
      end
    end
  end

  assign ent_o    = comp;
  assign cnt_o    = kept;
  assign member_o = member_q;

  always_comb begin
    int n;
    ent_d    = '0;
    pop_mask = '0;
    for (int j = 0; j < NV; j++) begin
      int s;
      s = j + int'(pop_n_i);
      if (s < int'(kept)) ent_d[j] = comp[s[VW-1:0]];
      if (j < int'(pop_n_i)) pop_mask[comp[j]] = 1'b1;
    end
    n = int'(kept) - int'(pop_n_i);
    for (int v = 0; v < NV; v++) begin
      if (push_i[v]) begin
        if (n < NV) ent_d[n[VW-1:0]] = VW'(v);
        n = n + 1;
      end
    end
    cnt_d    = CW'(n);
    member_d = (member_q & ~rm_i & ~pop_mask) | push_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q    <= '0;
      cnt_q    <= '0;
      member_q <= '0;
    end else begin
      ent_q    <= ent_d;
      cnt_q    <= cnt_d;
      member_q <= member_d;
    end
  end

  // R12
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= NV);
  // R12
  member_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(member_q) == int'(cnt_q));
  // R4
  push_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i & member_q) == '0);
endmodule

// File: rtl/vdma_alloc_scan.sv
module vdma_alloc_scan #(
  parameter int NV = 16,
  parameter int NP = 6,
  parameter int VW = 4,
  parameter int CW = 5
) (
  input  logic [NP-1:0]          free_i,
  input  logic [NV-1:0][VW-1:0]  ent_i,
  input  logic [CW-1:0]          cnt_i,
  output logic [NP-1:0]          grant_o,
  output logic [NP-1:0][VW-1:0]  gvch_o,
  output logic [CW-1:0]          pop_n_o
);
  // ascending physical scan, oldest entry first
  always_comb begin
    logic [CW-1:0] k;
    k       = '0;
    grant_o = '0;
    gvch_o  = '0;
    for (int p = 0; p < NP; p++) begin
      if (free_i[p] && k < cnt_i) begin
        grant_o[p] = 1'b1;
        gvch_o[p]  = ent_i[k[VW-1:0]];
        k          = k + 1'b1;
      end
    end
    pop_n_o = k;
  end
endmodule

// File: rtl/vdma_bind_slot.sv
module vdma_bind_slot #(
  parameter int NV = 16,
  parameter int VW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          grant_i,
  input  logic [VW-1:0] gvch_i,
  input  logic [NV-1:0] done_i,
  input  logic [NV-1:0] term_i,
  input  logic [NV-1:0] pause_i,
  input  logic [NV-1:0] resume_i,
  input  logic [NV-1:0] paused_i,
  output logic          valid_o,
  output logic [VW-1:0] vch_o,
  output logic          run_o,
  output logic          start_o
);
  logic          valid_q, run_q, start_q;
  logic [VW-1:0] vch_q;
  logic          rel, hold, go;

  assign rel  = valid_q && (done_i[vch_q] || term_i[vch_q]);
  assign hold = valid_q && pause_i[vch_q] && !paused_i[vch_q];
  assign go   = valid_q && resume_i[vch_q] && paused_i[vch_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vch_q   <= '0;
      run_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= !valid_q && grant_i;
      if (rel) begin
        valid_q <= 1'b0;
        run_q   <= 1'b0;
      end else if (!valid_q && grant_i) begin
        valid_q <= 1'b1;
        vch_q   <= gvch_i;
        run_q   <= 1'b1;
      end else if (hold) begin
        run_q <= 1'b0;
      end else if (go) begin
        run_q <= 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign vch_o   = vch_q;
  assign run_o   = run_q;
  assign start_o = start_q;

  // R11
  start_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> valid_q);
  // R3
  grant_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> !valid_q);
  // R6
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && done_i[vch_q]) |=> !valid_q);
  // R10
  pause_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold && !rel) |=> (valid_q && !run_q));
endmodule

// File: rtl/vdma_chan_alloc.sv
module vdma_chan_alloc #(
  parameter int NUM_VCH = 16,
  parameter int NUM_PCH = 6,
  localparam int VW = vdma_alloc_pkg::idx_w(NUM_VCH),
  localparam int CW = $clog2(NUM_VCH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_VCH-1:0]      issue_i,
  input  logic [NUM_VCH-1:0]      work_i,
  input  logic [NUM_VCH-1:0]      pause_i,
  input  logic [NUM_VCH-1:0]      resume_i,
  input  logic [NUM_VCH-1:0]      term_i,
  input  logic [NUM_VCH-1:0]      done_i,
  output logic [NUM_PCH*VW-1:0]   bind_vch_o,
  output logic [NUM_PCH-1:0]      bind_valid_o,
  output logic [NUM_VCH-1:0]      bound_o,
  output logic [NUM_PCH-1:0]      start_o,
  output logic [NUM_PCH-1:0]      run_en_o
);
  logic [NUM_VCH-1:0]              paused_q, member, rm, push;
  logic [NUM_VCH-1:0][VW-1:0]      ent;
  logic [CW-1:0]                   cnt, pop_n;
  logic [NUM_PCH-1:0]              grant, valid;
  logic [NUM_PCH-1:0][VW-1:0]      gvch, vch;
  logic [NUM_VCH-1:0][NUM_PCH-1:0] match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) paused_q <= '0;
    else         paused_q <= (paused_q | pause_i) & ~(resume_i & paused_q);
  end

  assign rm   = (pause_i & ~paused_q) | term_i;
  assign push = ~bound_o & ~member & ~term_i &
                ((issue_i & ~paused_q & ~pause_i) | (resume_i & paused_q & work_i));

  vdma_pend_queue #(.NV(NUM_VCH), .VW(VW), .CW(CW)) u_queue (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rm_i     (rm),
    .pop_n_i  (pop_n),
    .push_i   (push),
    .ent_o    (ent),
    .cnt_o    (cnt),
    .member_o (member)
  );

  vdma_alloc_scan #(.NV(NUM_VCH), .NP(NUM_PCH), .VW(VW), .CW(CW)) u_scan (
    .free_i  (~valid),
    .ent_i   (ent),
    .cnt_i   (cnt),
    .grant_o (grant),
    .gvch_o  (gvch),
    .pop_n_o (pop_n)
  );

  for (genvar p = 0; p < NUM_PCH; p++) begin : g_slot
    vdma_bind_slot #(.NV(NUM_VCH), .VW(VW)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .grant_i  (grant[p]),
      .gvch_i   (gvch[p]),
      .done_i   (done_i),
      .term_i   (term_i),
      .pause_i  (pause_i),
      .resume_i (resume_i),
      .paused_i (paused_q),
      .valid_o  (valid[p]),
      .vch_o    (vch[p]),
      .run_o    (run_en_o[p]),
      .start_o  (start_o[p])
    );
    assign bind_vch_o[p*VW +: VW] = vch[p];
  end

  for (genvar v = 0; v < NUM_VCH; v++) begin : g_vch
    for (genvar p = 0; p < NUM_PCH; p++) begin : g_m
      assign match[v][p] = valid[p] && (vch[p] == VW'(v));
    end
    assign bound_o[v] = |match[v];

    // R4
    single_bind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(match[v]));
    // R8
    paused_not_queued_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pause_i[v] && !paused_q[v] && !bound_o[v]) |=> !member[v]);
  end

  assign bind_valid_o = valid;
endmodule

// File: tb/vdma_chan_alloc_tb.sv
module vdma_chan_alloc_tb;
  localparam int NV = 16;
  localparam int NP = 6;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NV-1:0] issue_i = '0, work_i = '0, pause_i = '0, resume_i = '0, term_i = '0, done_i = '0;
  logic [NP*VW-1:0] bind_vch_o;
  logic [NP-1:0] bind_valid_o, start_o, run_en_o;
  logic [NV-1:0] bound_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  vdma_chan_alloc #(.NUM_VCH(NV), .NUM_PCH(NP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_i(issue_i), .work_i(work_i), .pause_i(pause_i),
    .resume_i(resume_i), .term_i(term_i), .done_i(done_i),
    .bind_vch_o(bind_vch_o), .bind_valid_o(bind_valid_o),
    .bound_o(bound_o), .start_o(start_o), .run_en_o(run_en_o)
  );

  function automatic logic [NV-1:0] b(input int v);
    return NV'(1) << v;
  endfunction

  function automatic int bvch(input int p);
    return int'(bind_vch_o[p*VW +: VW]);
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", r, act, exp);
    end
  endtask

  task automatic expect_start(input int p, input int v);
    exp_q.push_back({4'(p), 4'(v)});
  endtask

  // one event cycle: inputs seen at a single rising edge
  task automatic drive(input logic [NV-1:0] iss, input logic [NV-1:0] pau,
                       input logic [NV-1:0] res, input logic [NV-1:0] trm,
                       input logic [NV-1:0] dne);
    issue_i = iss; pause_i = pau; resume_i = res; term_i = trm; done_i = dne;
    @(negedge clk);
    issue_i = '0; pause_i = '0; resume_i = '0; term_i = '0; done_i = '0;
  endtask

  task automatic idle();
    drive('0, '0, '0, '0, '0);
  endtask

  // scoreboard monitor for start pulses (R11)
  always @(negedge clk) begin
    if (rst_ni) begin
      for (int p = 0; p < NP; p++) begin
        if (start_o[p]) begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R11 start pch %0d act vch %0d exp none", p, bvch(p));
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (e != {4'(p), 4'(bvch(p))}) begin
              errors++;
              $display("FAIL R3 start act pch %0d vch %0d exp pch %0d vch %0d",
                       p, bvch(p), e[7:4], e[3:0]);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid", int'(bind_valid_o), 0);
    chk("R1 bound", int'(bound_o), 0);
    chk("R1 run", int'(run_en_o), 0);
    chk("R1 start", int'(start_o), 0);

    // R2 single issue
    expect_start(0, 3);
    drive(b(3), '0, '0, '0, '0);
    idle();
    chk("R2 valid", int'(bind_valid_o), 1);
    chk("R2 vch", bvch(0), 3);
    chk("R2 bound", int'(bound_o[3]), 1);
    chk("R2 run", int'(run_en_o[0]), 1);

    // R4 repeats ignored
    drive(b(3), '0, '0, '0, '0);
    idle();
    chk("R4 bound reissue", int'(bind_valid_o), 1);
    expect_start(1, 5);
    drive(b(5), '0, '0, '0, '0);
    drive(b(5), '0, '0, '0, '0);
    idle();
    chk("R4 queued reissue", int'(bind_valid_o), 3);

    // R3 burst in one cycle, ascending order
    expect_start(2, 1); expect_start(3, 7); expect_start(4, 9); expect_start(5, 12);
    drive(b(9) | b(7) | b(12) | b(1), '0, '0, '0, '0);
    idle();
    chk("R11 multi start", $countones(start_o), 4);
    idle();
    chk("R11 pulse width", int'(start_o), 0);
    chk("R3 all bound", int'(bind_valid_o), 63);
    chk("R3 pch3 vch", bvch(3), 7);

    // R5 wait while full
    drive(b(14), '0, '0, '0, '0);
    drive(b(10), '0, '0, '0, '0);
    idle(); idle();
    chk("R5 waiting 14", int'(bound_o[14]), 0);
    chk("R5 waiting 10", int'(bound_o[10]), 0);

    // R6 done releases
    drive('0, '0, '0, '0, b(7));
    chk("R6 valid", int'(bind_valid_o[3]), 0);
    chk("R6 bound", int'(bound_o[7]), 0);
    expect_start(3, 14);
    idle();
    chk("R5 oldest first", bvch(3), 14);

    // R8 pause removes waiting channel
    drive('0, b(10), '0, '0, '0);
    drive('0, '0, '0, '0, b(9));
    idle(); idle();
    chk("R8 freed unused", int'(bind_valid_o[4]), 0);
    chk("R8 not bound", int'(bound_o[10]), 0);

    // R9 resume with work
    work_i = b(10);
    expect_start(4, 10);
    drive('0, '0, b(10), '0, '0);
    idle();
    chk("R9 resumed bind", bvch(4), 10);
    work_i = '0;
    // R9 resume without work; R8 held issue
    drive('0, '0, '0, '0, b(12));
    drive('0, b(11), '0, '0, '0);
    drive(b(11), '0, '0, '0, '0);
    idle();
    chk("R8 held issue ignored", int'(bind_valid_o[5]), 0);
    drive('0, '0, b(11), '0, '0);
    idle(); idle();
    chk("R9 no work no bind", int'(bind_valid_o[5]), 0);
    expect_start(5, 11);
    drive(b(11), '0, '0, '0, '0);
    idle();
    chk("R9 issue after resume", bvch(5), 11);

    // R10 pause/resume bound
    drive('0, b(1), '0, '0, '0);
    chk("R10 run off", int'(run_en_o[2]), 0);
    chk("R10 kept", int'(bind_valid_o[2]), 1);
    drive('0, '0, b(1), '0, '0);
    chk("R10 run on", int'(run_en_o[2]), 1);

    // R7 terminate bound and waiting
    drive('0, '0, '0, b(3), '0);
    chk("R7 valid", int'(bind_valid_o[0]), 0);
    chk("R7 run", int'(run_en_o[0]), 0);
    chk("R7 bound", int'(bound_o[3]), 0);
    expect_start(0, 2);
    drive(b(2), '0, '0, '0, '0);
    idle();
    chk("R7 rebind", bvch(0), 2);
    drive(b(6), '0, '0, '0, '0);
    drive('0, '0, '0, b(6), '0);
    drive('0, '0, '0, '0, b(5));
    idle(); idle();
    chk("R7 waiting cancelled", int'(bind_valid_o[1]), 0);

    // R12 deep line served in order
    expect_start(1, 0);
    drive('1, '0, '0, '0, '0);
    idle();
    chk("R12 head", bvch(1), 0);
    expect_start(0, 3);
    drive('0, '0, '0, '0, b(2));
    idle();
    chk("R12 second", bvch(0), 3);
    expect_start(2, 4);
    drive('0, '0, '0, '0, b(1));
    idle();
    chk("R12 third", bvch(2), 4);
    idle();
    chk("R11 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule